// File: doc/BRIEF.md
# Frame-Based Delay Converter

This block converts an audio delay expressed in video frames into a delay expressed in audio samples, for use by a lip-sync delay line. It reads one 8-bit configuration byte. The byte holds an enable bit, a video frame-rate select, an audio sample-rate select and a frame count from 0 to 7. From these it computes the sample count as the integer part of frames × sample rate ÷ frame rate.

Whenever the configuration byte changes, a new conversion starts. The product is formed in one step. A restoring divider then takes one quotient bit per clock. When the result is ready, the block presents it with a one-cycle `done` strobe. It also outputs a flag, taken from the enable bit, that tells the delay line to use this count instead of the per-channel counts programmed directly. A result too large for the output is clamped to the largest count that fits.

Top module: `frame_delay_conv`

## Requirements
- R1: After reset, `delay_samples` is 0, `use_frame` is 0 and `done` is 0.
- R2: `use_frame` equals bit 7 of the configuration that produced the result, and it updates in the same cycle as `delay_samples`.
- R3: Bit 6 selects the frame rate: 0 means 25 frames/s and 1 means 30 frames/s.
- R4: Bits 5:3 select the sample rate: 000 = 32000 Hz, 001 = 44100 Hz, 010 = 48000 Hz, 011 = 88200 Hz, 100 = 96000 Hz. Codes 101, 110 and 111 act as 48000 Hz.
- R5: Bits 2:0 give the frame count. A count of 0 yields a result of 0.
- R6: `delay_samples` = floor(frames × sample rate / frame rate) whenever that value fits in OUT_W bits.
- R7: A computed value above 2^OUT_W − 1 is reported as 2^OUT_W − 1 (8191 for OUT_W = 13).
- R8: A change of `cfg` seen at a rising edge starts a conversion. `done` is high for exactly one cycle after the 21st rising edge, counting that edge as the first.
- R9: While `cfg` holds its value and no conversion is running, `done` stays low and the outputs hold.
- R10: A change of `cfg` during a conversion abandons that conversion and restarts on the new value. Only the new value's result is reported, with a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 8 | Frame-delay configuration byte |
| delay_samples | output | OUT_W | Delay in audio samples, clamped |
| use_frame | output | 1 | Use this count instead of the per-channel counts |
| done | output | 1 | One-cycle strobe: new result valid |

## Verification
The bench builds two copies that share the same stimulus. One uses the default OUT_W = 13. The other uses OUT_W = 15, which is wide enough for the largest possible result (26880). The narrow copy therefore shows the clamp at 8191. The wide copy shows the exact quotient for the same inputs, which confirms that clamping happens only after division and does not mask a wrong quotient.

// File: rtl/frame_delay_conv.sv
module frame_delay_conv #(
  parameter int OUT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cfg,
  output logic [OUT_W-1:0] delay_samples,
  output logic             use_frame,
  output logic             done
);
  localparam int PW = 20;
  localparam int CW = $clog2(PW + 1);
  localparam logic [PW-1:0] MAXV = (PW'(1) << OUT_W) - PW'(1);

  logic [7:0]    cfg_q;
  logic [PW-1:0] dvd;
  logic [4:0]    rem, dvs;
  logic [CW-1:0] cnt;
  logic          busy;

  function automatic logic [16:0] rate_of(input logic [2:0] code);
    case (code)
      3'd0:    rate_of = 17'd32000;
      3'd1:    rate_of = 17'd44100;
      3'd3:    rate_of = 17'd88200;
      3'd4:    rate_of = 17'd96000;
      default: rate_of = 17'd48000;
    endcase
  endfunction

  wire           changed = cfg != cfg_q;
  wire [PW-1:0]  product = PW'(cfg[2:0]) * PW'(rate_of(cfg[5:3]));
  wire [5:0]     trial   = {rem, dvd[PW-1]};
  wire           take    = trial >= {1'b0, dvs};
  wire [5:0]     diff    = trial - {1'b0, dvs};
  wire [PW-1:0]  qnext   = {dvd[PW-2:0], take};
  wire [OUT_W-1:0] clamped = (qnext > MAXV) ? OUT_W'(MAXV) : OUT_W'(qnext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; dvd <= '0; rem <= '0; dvs <= 5'd25; cnt <= '0; busy <= 1'b0;
      delay_samples <= '0; use_frame <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (changed) begin
        cfg_q <= cfg;
        dvd   <= product;
        rem   <= '0;
        dvs   <= cfg[6] ? 5'd30 : 5'd25;
        cnt   <= CW'(PW);
        busy  <= 1'b1;
      end else if (busy) begin
        dvd <= qnext;
        rem <= take ? diff[4:0] : trial[4:0];
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy          <= 1'b0;
          done          <= 1'b1;
          delay_samples <= clamped;
          use_frame     <= cfg_q[7];
        end
      end
    end
  end

  p_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> use_frame == cfg_q[7]);
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((delay_samples == '0) == (cfg_q[2:0] == 3'd0)));
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> busy && cfg_q == $past(cfg));
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !changed) |=> !done);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(delay_samples) && $stable(use_frame)) |-> done);
endmodule

// File: tb/sim_frame_delay_conv.sv
module sim_frame_delay_conv;
  localparam int PERIOD = 10;
  localparam int LAT = 21;
  localparam int N = 17;
  localparam logic [7:0] CFG [N] = '{8'h91, 8'hD1, 8'h83, 8'hC9, 8'h89, 8'hCF, 8'hDA, 8'hA2,
                                      8'hE2, 8'h3D, 8'hE9, 8'h81, 8'hC7, 8'hDF, 8'h4B, 8'hB0, 8'h01};
  localparam int EXP [N] = '{1920, 1600, 3840, 1470, 1764, 10290, 5880, 7680,
                             6400, 9600, 1600, 1280, 7466, 20580, 4410, 0, 1280};

  logic clk = 0, rst_n = 0;
  logic [7:0] cfg = 8'h00;
  logic [12:0] ds0; logic [14:0] ds1;
  logic uf0, uf1, dn0, dn1;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  frame_delay_conv #(.OUT_W(13)) u0 (.clk(clk), .rst_n(rst_n), .cfg(cfg),
    .delay_samples(ds0), .use_frame(uf0), .done(dn0));
  frame_delay_conv #(.OUT_W(15)) u1 (.clk(clk), .rst_n(rst_n), .cfg(cfg),
    .delay_samples(ds1), .use_frame(uf1), .done(dn1));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [7:0] c, input int e, input string tag);
    int first = 0;
    int e0 = (e > 8191) ? 8191 : e;
    @(negedge clk); cfg = c;
    for (int n = 1; n <= LAT + 3; n++) begin
      @(negedge clk);
      if (dn0 && first == 0) first = n;
      if (n == LAT) begin
        check(ds0 == 13'(e0), tag, int'(ds0), e0);
        check(ds1 == 15'(e), tag, int'(ds1), e);
        check(uf0 == c[7] && uf1 == c[7], "R2", int'(uf0), int'(c[7]));
      end
      if (n == LAT + 1) check(!dn0 && !dn1, "R8 pulse", int'(dn0), 0);
    end
    check(first == LAT, "R8 latency", first, LAT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ds0 == 0 && ds1 == 0, "R1 result", int'(ds0), 0);
    check(!uf0 && !dn0, "R1 flags", int'({uf0, dn0}), 0);
    rst_n = 1;
    for (int i = 0; i < N; i++) begin
      string tag;
      if (EXP[i] > 8191) tag = "R7";
      else if (CFG[i][5:3] > 3'd4) tag = "R4";
      else if (CFG[i][2:0] == 3'd0) tag = "R5";
      else if (CFG[i][6]) tag = "R3";
      else tag = "R6";
      run_one(CFG[i], EXP[i], tag);
    end
    begin : r9_hold
      int seen = 0;
      @(negedge clk); cfg = 8'h01;
      for (int n = 0; n < 40; n++) begin
        @(negedge clk);
        if (dn0 || ds0 != 13'd1280) seen++;
      end
      check(seen == 0, "R9", seen, 0);
    end
    begin : r10_restart
      int dones = 0, first = 0;
      @(negedge clk); cfg = 8'hC9;
      repeat (5) @(negedge clk);
      cfg = 8'h89;
      for (int n = 1; n <= LAT + 10; n++) begin
        @(negedge clk);
        if (dn0) begin dones++; if (first == 0) first = n; end
      end
      check(first == LAT, "R10 timing", first, LAT);
      check(dones == 1, "R10 single done", dones, 1);
      check(ds0 == 13'd1764, "R10 value", int'(ds0), 1764);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule